// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a parameterized number of asynchronous interrupt lines and merges them into one interrupt request for a processor. Lines are packed 32 to a word. Every line has its own configuration bits: a mask, a choice of edge or level detection, an active polarity, a software trigger and a routing enable. All of them sit in a small register bank decoded from a 12-bit byte address. Each line's input is synchronized. The selected event is then latched into a pending bit, which software clears by writing ones to an acknowledge word.

The mask, sensitivity, soft-trigger and polarity fields are each reached through three addresses. One is a read view. One sets the bits that are written as 1. One clears the bits that are written as 1. Software can therefore change one line without a read-modify-write. The routing-enable field is an ordinary read/write word. The output request is high whenever some line is pending, routed and unmasked.

Top module: `xint_ctrl`

## Requirements
- R1: After reset every mask bit reads 1. Status, sensitivity, soft, polarity and routing-enable words read 0, and `irq_out` is 0.
- R2: Line n is bit n mod 32 of the word at group base + 4*(n/32). Writing 1s to a set alias sets those bits and writing 1s to a clear alias clears them. Bits written 0 keep their value. The view/set/clear bases are mask 0x080/0x0C0/0x100, sensitivity 0x140/0x180/0x1C0, soft 0x200/0x240/0x280 and polarity 0x300/0x340/0x380.
- R3: With sensitivity 0 (edge), a line sets its status bit (view at 0x000) only on the transition into its active value. Polarity 1 means a rising edge and polarity 0 means a falling edge. The input passes through a two-flop synchronizer first.
- R4: With sensitivity 1 (level), status stays set while the line sits at its active level (1 for polarity 1, 0 for polarity 0), even across an acknowledge. Once the level goes inactive, status stays set until it is acknowledged.
- R5: Writing 1s to the acknowledge word at 0x040 clears those status bits unless a set condition holds for them in the same cycle. Bits written 0 are untouched.
- R6: A set soft bit holds the line's status set, as a real event would. After a soft-clear, an acknowledge clears the status.
- R7: `irq_out` is high exactly when some line has status 1, routing enable 1 and mask 0.
- R8: The following read as zero and ignore writes: unmapped groups, word indices at or beyond the number of ports, addresses not aligned to 4 bytes, and the acknowledge, set and clear aliases.
- R9: The routing-enable word at 0x400 + 4*k is plain read/write, and a write replaces the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Write strobe for the addressed register, one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following: the reset values, the set and clear behaviour of the mask aliases, the status of a level line staying set while the line is active, the request requiring some routed and unmasked line, and unmapped groups reading zero. Some behaviour can only be shown by the bench scenarios. This covers the synchronizer latency, detection of only the chosen edge direction, a status bit that was latched surviving the end of a level, the soft trigger defeating an acknowledge, and writes to unmapped addresses leaving every register unchanged.

// File: rtl/xint_ctrl.sv
module xint_ctrl #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_irq,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_out
);
  localparam int PORTS = (NUM_LINES + 31) / 32;
  localparam int W = PORTS * 32;
  localparam logic [W:0] ONE_X = 1;
  localparam logic [W-1:0] VALID = W'((ONE_X << NUM_LINES) - ONE_X);

  logic [5:0] grp;
  logic [3:0] widx;
  logic [8:0] sh;
  logic word_ok, wr_ok;
  logic [W-1:0] wbits, wword;
  logic [W-1:0] ack_b, mset_b, mclr_b, sset_b, sclr_b, fset_b, fclr_b, pset_b, pclr_b;
  logic dom_wr;

  logic [W-1:0] sync1_q, sync2_q, prev_q;
  logic [W-1:0] mask_q, sens_q, soft_q, pol_q, dom_q, stat_q;
  logic [W-1:0] lvl, edg, setc;

  assign grp = bus_addr[11:6];
  assign widx = bus_addr[5:2];
  assign sh = {widx, 5'b0};
  assign word_ok = (bus_addr[1:0] == 2'b00) && (int'(widx) < PORTS);
  assign wr_ok = bus_wr && word_ok;
  assign wbits = (W'(bus_wdata) << sh) & VALID;
  assign wword = (W'(32'hFFFF_FFFF) << sh) & VALID;

  assign ack_b  = (wr_ok && grp == 6'd1)  ? wbits : '0;
  assign mset_b = (wr_ok && grp == 6'd3)  ? wbits : '0;
  assign mclr_b = (wr_ok && grp == 6'd4)  ? wbits : '0;
  assign sset_b = (wr_ok && grp == 6'd6)  ? wbits : '0;
  assign sclr_b = (wr_ok && grp == 6'd7)  ? wbits : '0;
  assign fset_b = (wr_ok && grp == 6'd9)  ? wbits : '0;
  assign fclr_b = (wr_ok && grp == 6'd10) ? wbits : '0;
  assign pset_b = (wr_ok && grp == 6'd13) ? wbits : '0;
  assign pclr_b = (wr_ok && grp == 6'd14) ? wbits : '0;
  assign dom_wr = wr_ok && grp == 6'd16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= W'(ext_irq);
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign lvl  = ~(sync2_q ^ pol_q);
  assign edg  = (sync2_q ^ prev_q) & lvl;
  assign setc = ((sens_q & lvl) | (~sens_q & edg) | soft_q) & VALID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= VALID;
      sens_q <= '0;
      soft_q <= '0;
      pol_q  <= '0;
      dom_q  <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= (mask_q | mset_b) & ~mclr_b;
      sens_q <= (sens_q | sset_b) & ~sclr_b;
      soft_q <= (soft_q | fset_b) & ~fclr_b;
      pol_q  <= (pol_q  | pset_b) & ~pclr_b;
      if (dom_wr) dom_q <= (dom_q & ~wword) | wbits;
      stat_q <= setc | (stat_q & ~ack_b);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      case (grp)
        6'd0:  bus_rdata = 32'(stat_q >> sh);
        6'd2:  bus_rdata = 32'(mask_q >> sh);
        6'd5:  bus_rdata = 32'(sens_q >> sh);
        6'd8:  bus_rdata = 32'(soft_q >> sh);
        6'd12: bus_rdata = 32'(pol_q >> sh);
        6'd16: bus_rdata = 32'(dom_q >> sh);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_out = |(stat_q & dom_q & ~mask_q);
endmodule

module xint_ctrl_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [11:0]  bus_addr,
  input logic [31:0]  bus_wdata,
  input logic [31:0]  bus_rdata,
  input logic         irq_out,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] dom_q,
  input logic [W-1:0] sens_q,
  input logic [W-1:0] pol_q,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] sync2_q
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q[31:0]) && stat_q == '0 && dom_q == '0 && !irq_out);

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h0C0) |=> mask_q[31:0] == ($past(mask_q[31:0]) | $past(bus_wdata)));

  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h100) |=> mask_q[31:0] == ($past(mask_q[31:0]) & ~$past(bus_wdata)));

  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_q[0] && (sync2_q[0] == pol_q[0])) |=> stat_q[0]);

  p_irq_needs_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> |(dom_q & ~mask_q));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[11:6] == 6'd11 || bus_addr[11:6] == 6'd15) |-> bus_rdata == 32'h0);
endmodule

bind xint_ctrl xint_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .mask_q(mask_q), .dom_q(dom_q), .sens_q(sens_q), .pol_q(pol_q),
  .stat_q(stat_q), .sync2_q(sync2_q)
);

// File: tb/xint_ctrl_test.sv
module xint_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int N = 64;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] ext_irq = '0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  xint_ctrl #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // {req tag number, is_read, addr, wdata, expected read}
  localparam logic [80:0] VEC [NV] = '{
    {4'd1, 1'b1, 12'h080, 32'h0, 32'hFFFF_FFFF},        // R1
    {4'd1, 1'b1, 12'h084, 32'h0, 32'hFFFF_FFFF},        // R1
    {4'd1, 1'b1, 12'h000, 32'h0, 32'h0},                // R1
    {4'd1, 1'b1, 12'h300, 32'h0, 32'h0},                // R1
    {4'd1, 1'b1, 12'h140, 32'h0, 32'h0},                // R1
    {4'd1, 1'b1, 12'h400, 32'h0, 32'h0},                // R1
    {4'd2, 1'b0, 12'h340, 32'hA5A5_0000, 32'h0},        // R2
    {4'd2, 1'b1, 12'h300, 32'h0, 32'hA5A5_0000},        // R2
    {4'd2, 1'b0, 12'h380, 32'h0005_0000, 32'h0},        // R2
    {4'd2, 1'b1, 12'h300, 32'h0, 32'hA5A0_0000},        // R2
    {4'd2, 1'b0, 12'h344, 32'h1, 32'h0},                // R2
    {4'd2, 1'b1, 12'h304, 32'h0, 32'h1},                // R2
    {4'd2, 1'b1, 12'h300, 32'h0, 32'hA5A0_0000},        // R2
    {4'd2, 1'b0, 12'h104, 32'hFFFF_0000, 32'h0},        // R2
    {4'd2, 1'b1, 12'h084, 32'h0, 32'h0000_FFFF},        // R2
    {4'd2, 1'b0, 12'h0C4, 32'h0001_0000, 32'h0},        // R2
    {4'd2, 1'b1, 12'h084, 32'h0, 32'h0001_FFFF},        // R2
    {4'd8, 1'b0, 12'h2C0, 32'hFFFF_FFFF, 32'h0},        // R8
    {4'd8, 1'b1, 12'h2C0, 32'h0, 32'h0},                // R8
    {4'd8, 1'b1, 12'h084, 32'h0, 32'h0001_FFFF},        // R8
    {4'd8, 1'b1, 12'h340, 32'h0, 32'h0},                // R8
    {4'd8, 1'b1, 12'h088, 32'h0, 32'h0},                // R8
    {4'd8, 1'b1, 12'h302, 32'h0, 32'h0},                // R8
    {4'd9, 1'b0, 12'h400, 32'hF0, 32'h0},               // R9
    {4'd9, 1'b1, 12'h400, 32'h0, 32'hF0},               // R9
    {4'd9, 1'b0, 12'h400, 32'h0F, 32'h0},               // R9
    {4'd9, 1'b1, 12'h400, 32'h0, 32'h0F},               // R9
    {4'd9, 1'b0, 12'h400, 32'h0, 32'h0},                // R9
    {4'd2, 1'b0, 12'h380, 32'hFFFF_FFFF, 32'h0},        // R2
    {4'd2, 1'b0, 12'h384, 32'hFFFF_FFFF, 32'h0},        // R2
    {4'd2, 1'b0, 12'h0C4, 32'hFFFF_FFFF, 32'h0},        // R2
    {4'd2, 1'b1, 12'h304, 32'h0, 32'h0}                 // R2
  };

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %h: actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    #1;
    n_chk++;
    if (irq_out !== exp) begin
      n_bad++;
      $display("FAIL %s irq_out: actual %b expected %b", tag, irq_out, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    irq_chk(1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    irq_chk(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) rd_chk(VEC[i][75:64], VEC[i][31:0], $sformatf("R%0d row %0d", VEC[i][80:77], i));
      else wr(VEC[i][75:64], VEC[i][63:32]);
    end

    // R3 rising edge on line 0
    wr(12'h340, 32'h1);
    @(negedge clk); ext_irq[0] = 1'b1;
    settle();
    rd_chk(12'h000, 32'h1, "R3 rising");
    wr(12'h040, 32'h1);                       // R5 ack with input still high
    settle();
    rd_chk(12'h000, 32'h0, "R5 ack edge");
    @(negedge clk); ext_irq[0] = 1'b0;
    settle();
    rd_chk(12'h000, 32'h0, "R3 falling ignored");

    // R3 falling edge on lines 1 and 2 (polarity 0)
    @(negedge clk); ext_irq[2:1] = 2'b11;
    settle();
    rd_chk(12'h000, 32'h0, "R3 rising ignored");
    @(negedge clk); ext_irq[2:1] = 2'b00;
    settle();
    rd_chk(12'h000, 32'h6, "R3 falling");
    wr(12'h040, 32'h2);
    settle();
    rd_chk(12'h000, 32'h4, "R5 partial ack");
    wr(12'h040, 32'h4);
    settle();
    rd_chk(12'h000, 32'h0, "R5 second ack");

    // R4 level line 33, active high
    wr(12'h344, 32'h2);
    wr(12'h184, 32'h2);
    @(negedge clk); ext_irq[33] = 1'b1;
    settle();
    rd_chk(12'h004, 32'h2, "R4 level set");
    wr(12'h044, 32'h2);
    settle();
    rd_chk(12'h004, 32'h2, "R4 held across ack");
    @(negedge clk); ext_irq[33] = 1'b0;
    settle();
    rd_chk(12'h004, 32'h2, "R4 latched after level");
    wr(12'h044, 32'h2);
    settle();
    rd_chk(12'h004, 32'h0, "R4 ack after level");
    wr(12'h1C4, 32'h2);
    wr(12'h384, 32'h2);

    // R6 soft trigger on line 5
    wr(12'h240, 32'h20);
    settle();
    rd_chk(12'h200, 32'h20, "R6 soft view");
    rd_chk(12'h000, 32'h20, "R6 soft status");
    wr(12'h040, 32'h20);
    settle();
    rd_chk(12'h000, 32'h20, "R6 ack while soft");
    wr(12'h280, 32'h20);
    wr(12'h040, 32'h20);
    settle();
    rd_chk(12'h000, 32'h0, "R6 cleared");

    // R7 combined output via line 40
    wr(12'h244, 32'h100);
    settle();
    irq_chk(1'b0, "R7 masked");
    wr(12'h104, 32'h100);
    settle();
    irq_chk(1'b0, "R7 not routed");
    wr(12'h404, 32'h100);
    irq_chk(1'b1, "R7 routed");
    wr(12'h0C4, 32'h100);
    irq_chk(1'b0, "R7 remasked");
    wr(12'h104, 32'h100);
    irq_chk(1'b1, "R7 unmasked");
    wr(12'h284, 32'h100);
    wr(12'h044, 32'h100);
    settle();
    irq_chk(1'b0, "R7 after ack");
    rd_chk(12'h404, 32'h100, "R9 word1");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule